// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multi-cycle processor, organised as a microcode store. A small microaddress register selects one 19-bit control word. The upper 17 bits of that word go straight to the datapath as control points. The lowest 2 bits form a sequencing code, and this code decides where the register points on the next clock.

The next microaddress comes from one of four sources: zero (a return to instruction fetch), one of two dispatch tables indexed by the 6-bit opcode, or the current address plus one. The control store and both dispatch tables are fixed inside the block. Each state takes exactly one control word, and the sequencing code of that word alone chooses the successor.

Top module: `useq_top`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied, `uaddr` is 0 and `ctrl` shows the output bits of word 0.
- R2: `ctrl` equals the 17 output bits (word bits 18:2) of the word at `uaddr`, read combinationally. The words are: 0 = 10010100000001000, 1 = 00000000010011000, 2 = 00000000000010100, 3 = 00110000000010100, 4 = 00110000000010110, 5 = 00101000000010100, 6 = 00000000001000100, 7 = 00000000001000111, 8 = 01000000100100100, 9 = 10000001000000000.
- R3: Sequencing code 11 (words 0, 3, 6 and 10) loads `uaddr`+1 at the next rising edge.
- R4: Sequencing code 00 (words 4, 5, 7, 8, 9 and 11) loads 0 at the next rising edge.
- R5: Code 01 (word 1) dispatches on the opcode sampled at the edge through the first table: 100011 (load) and 101011 (store) go to 2, 000000 (register ALU) to 6, 000100 (branch on equal) to 8, 000010 (jump) to 9, and 001101 (OR immediate) to 10.
- R6: Code 10 (word 2) dispatches through the second table: 100011 goes to 3 and 101011 goes to 5.
- R7: If the opcode is missing from the table that is selected, the dispatch goes to microaddress 0.
- R8: Words 10 and 11 drive all 17 output bits to zero. Word 10 carries code 11 and word 11 carries code 00.
- R9: With opcode 100011 held, the sequence runs 0, 1, 2, 3, 4 and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Instruction opcode used by the dispatch steps |
| ctrl | output | 17 | Datapath control bits of the current word |
| uaddr | output | 4 | Current microaddress |

## Verification
On every clock cycle, the assertions check how each sequencing code relates to the next microaddress. Code 11 must move up by one. Code 00 must land on 0. Each dispatch must land on one of the legal targets of its table. Words 10 and 11 must output zeros.

Only the bench scenarios can show the exact per-opcode routes and the bit pattern of every control word. These scenarios include the full instruction walks, a dispatch on an unknown opcode, and an opcode change between the two dispatch steps.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int OPC_W   = 6;
  localparam int UADDR_W = 4;
  localparam int OUT_W   = 17;
  localparam int SEQ_W   = 2;
  localparam int WORD_W  = OUT_W + SEQ_W;

  typedef enum logic [SEQ_W-1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_DISP1 = 2'b01,
    SEQ_DISP2 = 2'b10,
    SEQ_NEXT  = 2'b11
  } seq_code_e;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_ALU    = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_ORI    = 6'b001101;

  function automatic logic [UADDR_W-1:0] addr_plus_one(input logic [UADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = UADDR_W
) (
  input  logic [AW-1:0]    addr,
  output logic [OUT_W-1:0] out_bits,
  output seq_code_e        code
);
  logic [WORD_W-1:0] word;

  // The contents are the fixed microprogram. Words past 11 are unused:
  // they output zeros and return to fetch.
  always_comb begin
    case (int'(addr))
      0:  word = {17'b10010100000001000, 2'b11};
      1:  word = {17'b00000000010011000, 2'b01};
      2:  word = {17'b00000000000010100, 2'b10};
      3:  word = {17'b00110000000010100, 2'b11};
      4:  word = {17'b00110000000010110, 2'b00};
      5:  word = {17'b00101000000010100, 2'b00};
      6:  word = {17'b00000000001000100, 2'b11};
      7:  word = {17'b00000000001000111, 2'b00};
      8:  word = {17'b01000000100100100, 2'b00};
      9:  word = {17'b10000001000000000, 2'b00};
      10: word = {17'b0, 2'b11};
      11: word = {17'b0, 2'b00};
      default: word = '0;
    endcase
  end

  assign out_bits = word[WORD_W-1:SEQ_W];
  assign code     = seq_code_e'(word[SEQ_W-1:0]);
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int TABLE_ID = 1,
  parameter int AW       = UADDR_W
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [AW-1:0]    target
);
  generate
    if (TABLE_ID == 1) begin : g_first
      always_comb begin
        case (opcode)
          OPC_LOAD, OPC_STORE: target = AW'(2);
          OPC_ALU:             target = AW'(6);
          OPC_BRANCH:          target = AW'(8);
          OPC_JUMP:            target = AW'(9);
          OPC_ORI:             target = AW'(10);
          default:             target = '0;
        endcase
      end
    end else begin : g_second
      always_comb begin
        case (opcode)
          OPC_LOAD:  target = AW'(3);
          OPC_STORE: target = AW'(5);
          default:   target = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = UADDR_W
) (
  input  seq_code_e     code,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] disp1,
  input  logic [AW-1:0] disp2,
  output logic [AW-1:0] nxt
);
  always_comb begin
    unique case (code)
      SEQ_FETCH: nxt = '0;
      SEQ_DISP1: nxt = disp1;
      SEQ_DISP2: nxt = disp2;
      SEQ_NEXT:  nxt = AW'(addr_plus_one(UADDR_W'(cur)));
      default:   nxt = '0;
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW = UADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic [OUT_W-1:0] ctrl,
  output logic [AW-1:0]    uaddr
);
  seq_code_e     seq_code;
  logic [AW-1:0] disp1_tgt;
  logic [AW-1:0] disp2_tgt;
  logic [AW-1:0] next_uaddr;

  useq_store #(.AW(AW)) u_store (
    .addr(uaddr), .out_bits(ctrl), .code(seq_code)
  );

  useq_dispatch #(.TABLE_ID(1), .AW(AW)) u_disp1 (
    .opcode(opcode), .target(disp1_tgt)
  );

  useq_dispatch #(.TABLE_ID(2), .AW(AW)) u_disp2 (
    .opcode(opcode), .target(disp2_tgt)
  );

  useq_next #(.AW(AW)) u_next (
    .code(seq_code), .cur(uaddr), .disp1(disp1_tgt), .disp2(disp2_tgt),
    .nxt(next_uaddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uaddr <= '0;
    else        uaddr <= next_uaddr;
  end

  // R3
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    seq_code == SEQ_NEXT |=> uaddr == AW'($past(uaddr) + 1'b1));

  // R4
  a_r4_back_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    seq_code == SEQ_FETCH |=> uaddr == '0);

  // R5, R7
  a_r5_disp1_legal: assert property (@(posedge clk) disable iff (!rst_n)
    seq_code == SEQ_DISP1 |=> (uaddr == AW'(0) || uaddr == AW'(2) || uaddr == AW'(6) ||
                               uaddr == AW'(8) || uaddr == AW'(9) || uaddr == AW'(10)));

  // R6, R7
  a_r6_disp2_legal: assert property (@(posedge clk) disable iff (!rst_n)
    seq_code == SEQ_DISP2 |=> (uaddr == AW'(0) || uaddr == AW'(3) || uaddr == AW'(5)));

  // R8
  a_r8_spare_words_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (uaddr == AW'(10) || uaddr == AW'(11)) |-> ctrl == '0);
endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = 6'b0;
  logic [16:0] ctrl;
  logic [3:0]  uaddr;

  useq_top dut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .ctrl(ctrl), .uaddr(uaddr));

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [5:0] LW  = 6'b100011;
  localparam logic [5:0] SW  = 6'b101011;
  localparam logic [5:0] RT  = 6'b000000;
  localparam logic [5:0] BEQ = 6'b000100;
  localparam logic [5:0] JMP = 6'b000010;
  localparam logic [5:0] ORI = 6'b001101;
  localparam logic [5:0] BAD = 6'b111111;

  int vectors = 0;
  int fails = 0;

  typedef struct {
    int          addr;
    logic [16:0] bits;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [16:0] word_bits(input int a);
    case (a)
      0: return 17'b10010100000001000;
      1: return 17'b00000000010011000;
      2: return 17'b00000000000010100;
      3: return 17'b00110000000010100;
      4: return 17'b00110000000010110;
      5: return 17'b00101000000010100;
      6: return 17'b00000000001000100;
      7: return 17'b00000000001000111;
      8: return 17'b01000000100100100;
      9: return 17'b10000001000000000;
      default: return 17'b0;
    endcase
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // Driver: state the expectation for the present cycle, then let one edge pass.
  task automatic step(input logic [5:0] op, input int a, input string tag);
    exp_t e;
    e.addr = a;
    e.bits = word_bits(a);
    e.tag  = tag;
    opcode = op;
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare once the driver has settled its inputs.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (int'(uaddr) != e.addr || ctrl !== e.bits) begin
          fails++;
          $display("FAIL %s: uaddr=%0d ctrl=%b expected uaddr=%0d ctrl=%b",
                   e.tag, uaddr, ctrl, e.addr, e.bits);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    vectors++; // R1 reset state
    if (uaddr !== 4'd0 || ctrl !== word_bits(0)) begin
      fails++;
      $display("FAIL R1: uaddr=%0d ctrl=%b expected uaddr=0 ctrl=%b", uaddr, ctrl, word_bits(0));
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R9 load walk, also covers R2 R3 R4 R5 R6
    step(LW, 0, "R9"); step(LW, 1, "R9"); step(LW, 2, "R5"); step(LW, 3, "R6");
    step(LW, 4, "R3");
    // store: R6 second table
    step(SW, 0, "R4"); step(SW, 1, "R2"); step(SW, 2, "R5"); step(SW, 5, "R6");
    // register ALU
    step(RT, 0, "R4"); step(RT, 1, "R2"); step(RT, 6, "R5"); step(RT, 7, "R3");
    // branch and jump
    step(BEQ, 0, "R4"); step(BEQ, 1, "R2"); step(BEQ, 8, "R5");
    step(JMP, 0, "R4"); step(JMP, 1, "R2"); step(JMP, 9, "R5");
    // OR immediate reaches the spare words: R8
    step(ORI, 0, "R4"); step(ORI, 1, "R2"); step(ORI, 10, "R8"); step(ORI, 11, "R8");
    // unknown opcode at first dispatch: R7
    step(BAD, 0, "R4"); step(BAD, 1, "R7"); step(BAD, 0, "R7");
    // opcode changes between dispatches, so table 2 misses: R7
    step(LW, 1, "R3"); step(RT, 2, "R5"); step(RT, 0, "R7");
    // store again, then the load path back to fetch: R9
    step(SW, 1, "R3"); step(SW, 2, "R5"); step(SW, 5, "R6"); step(SW, 0, "R4");
    step(LW, 1, "R3"); step(LW, 2, "R9"); step(LW, 3, "R9"); step(LW, 4, "R9");
    step(LW, 0, "R9");
    @(negedge clk);
    #2;
    summary();
    $finish;
  end
endmodule